// File: doc/BRIEF.md
# Break-Before-Make Switch Update Sequencer

This block sits between a small register write port and a bank of single-pole single-throw analog switches. Software writes a new switch-state byte to the switch data register, where each bit stands for one switch. The sequencer turns each write into two steps. In the open step, every switch that the new byte turns off is released at once. In the close step, which comes a programmable number of system clock cycles later, the switches that the new byte turns on are enabled. Two inputs that are about to be tied together through the bank are never connected at the same moment, so outputs that are wired together outside the chip can form multiplexers of any width.

While a transition waits out its dead time, the block reports busy. A write that arrives during that time is held in a single slot, and a later write replaces it. The held value is applied as soon as the current transition has finished. If an update only opens switches, or leaves them as they are, it completes in one cycle with no wait.

Top module: `bbm_switch_seq`

## Requirements
- R1: For the first cycle after reset, every switch enable is low, the register readback is 0x00 and busy is low.
- R2: A write to address 0x01 sets the switch pattern. Data bit i controls enable output i (bit 0 is the first switch). Once the transition is over, the enables equal the low N_SW data bits. For example, data 0x02 leaves only enable 1 high.
- R3: A write to any other address, or a cycle with the write enable low, leaves the enables and the readback unchanged.
- R4: In the cycle after a write that closes at least one switch is applied, the enables equal the old enables ANDed with the new value.
- R5: Newly closed switches turn on exactly D clock edges after the edge that applied the write, where D is dead_cycles, or 1 when dead_cycles is 0.
- R6: A switch that is on before an update and on in the new value stays on in every cycle of the transition.
- R7: An update that closes no switch sets the enables to the new value at the edge that applies it, and busy stays low.
- R8: busy is high in every cycle of a dead-time wait and while a queued write waits to be applied.
- R9: Of the writes that arrive during a transition, only the last one is kept. It is applied at the edge after the current transition ends, and goes through its own open and close steps.
- R10: The readback shows the value being applied, starting one cycle after the edge that applies it. Bits at and above N_SW read as zero.
- R11: At no clock edge does one enable rise while another falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register address of the write |
| wr_data | input | 8 | Write data; bit i controls switch i |
| dead_cycles | input | DEAD_W | Dead time between the open and close steps, in clock cycles |
| sw_en | output | N_SW | Switch enables, high means closed |
| sw_reg | output | 8 | Readback of the switch data register |
| busy | output | 1 | A transition or queued write is pending |

## Verification
The main function is tried with several kinds of update. Pure closes from the all-open state show the dead-time count. Swaps that open one switch and close another show the open-before-close order. Updates that overlap keep some bits on, which exposes glitches on switches held closed. Pure opens show the one-cycle path. Bursts of writes during a wait show that only the last queued value is applied. The dead time is set to zero and to small non-zero values, which tells the minimum-of-one rule apart from an off-by-one count. Constrained random writes, most of them to the switch address and some to other addresses, are compared each cycle against a reference model built from the requirements.

// File: rtl/bbm_pkg.sv
// Package: shared constants and types for the break-before-make sequencer.
// Assumes a 7-bit register address space with the switch data register at 0x01.
package bbm_pkg;
    localparam logic [6:0] SW_DATA_ADDR = 7'h01;
    localparam int         REG_W        = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_t;
endpackage

// File: rtl/bbm_pending_slot.sv
// Single-entry holding slot for a switch pattern written during a transition.
// Assumes capture and consume are never asserted in the same cycle; a new
// capture overwrites any value already held, so only the latest survives.
module bbm_pending_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] cap_data,
    input  logic         consume,
    output logic         valid,
    output logic [W-1:0] data
);
    // Hold the newest captured pattern until the controller consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (capture) begin
            valid <= 1'b1;
            data  <= cap_data;
        end else if (consume) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/bbm_dead_timer.sv
// Down-counter that measures the dead time between the open and close steps.
// Assumes load is pulsed on the edge that enters the wait; a load value of 0
// is treated as 1 so at least one cycle separates the two steps.
module bbm_dead_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    // Load remaining wait edges, then count down while the wait runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/bbm_switch_seq.sv
// Break-before-make switch update sequencer (top).
// Accepts writes to the switch data register and drives one enable per switch.
// Each update first applies old AND new (opens only). If any switch is being
// closed, it waits the dead time before applying the new value. Writes that
// arrive during a transition are queued in a single slot (latest wins).
// Assumes N_SW is 4 or 8 and inputs are synchronous to clk.
module bbm_switch_seq #(
    parameter int N_SW   = 8,
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [6:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic [N_SW-1:0]   sw_en,
    output logic [7:0]        sw_reg,
    output logic              busy
);
    import bbm_pkg::*;

    localparam int PAD_W = REG_W - N_SW;

    seq_state_t      state_q;
    logic [N_SW-1:0] en_q;
    logic [N_SW-1:0] tgt_q;
    logic [N_SW-1:0] reg_q;
    logic            wr_hit;
    logic [N_SW-1:0] wr_val;
    logic            pend_valid;
    logic [N_SW-1:0] pend_data;
    logic            in_wait;
    logic            start;
    logic [N_SW-1:0] next_val;
    logic            closes;
    logic            timer_done;

    // Decode a write aimed at the switch data register.
    always_comb begin
        wr_hit = wr_en && (wr_addr == SW_DATA_ADDR);
        wr_val = wr_data[N_SW-1:0];
    end

    assign in_wait = (state_q == ST_WAIT);

    // Pick the pattern to apply next and whether it closes any switch.
    always_comb begin
        start    = !in_wait && (wr_hit || pend_valid);
        next_val = wr_hit ? wr_val : pend_data;
        closes   = |(next_val & ~en_q);
    end

    bbm_pending_slot #(.W(N_SW)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (in_wait && wr_hit),
        .cap_data (wr_val),
        .consume  (start),
        .valid    (pend_valid),
        .data     (pend_data)
    );

    bbm_dead_timer #(.W(DEAD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start && closes),
        .load_val (dead_cycles),
        .run      (in_wait),
        .expire   (timer_done)
    );

    // Sequence each update through its open step and delayed close step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            en_q    <= '0;
            tgt_q   <= '0;
            reg_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        reg_q <= next_val;
                        if (closes) begin
                            en_q    <= en_q & next_val;
                            tgt_q   <= next_val;
                            state_q <= ST_WAIT;
                        end else begin
                            en_q <= next_val;
                        end
                    end
                end
                ST_WAIT: begin
                    if (timer_done) begin
                        en_q    <= tgt_q;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sw_en = en_q;
    assign busy  = in_wait || pend_valid;

    // Zero-extend the readback for a bank narrower than the register.
    generate
        if (PAD_W > 0) begin : g_pad
            assign sw_reg = {{PAD_W{1'b0}}, reg_q};
        end else begin : g_full
            assign sw_reg = reg_q[REG_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/bbm_switch_seq_chk.sv
// Checker for the break-before-make sequencer, attached by bind.
// Assumes reset is held low from time zero until after the first clock edge.
module bbm_switch_seq_chk #(
    parameter int N_SW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [6:0]      wr_addr,
    input logic [N_SW-1:0] sw_en,
    input logic [7:0]      sw_reg,
    input logic            busy,
    input logic            in_wait
);
    logic was_rst;

    // Remember that the previous edge saw reset.
    always_ff @(posedge clk) was_rst <= !rst_n;

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (sw_en == '0 && sw_reg == 8'h00 && !busy));

    p_no_swap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sw_en & ~$past(sw_en))) |-> !(|(~sw_en & $past(sw_en))));

    p_close_after_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sw_en & ~$past(sw_en))) |-> $past(in_wait));

    p_busy_in_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait |-> busy);

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(wr_en && wr_addr == 7'h01)) |=> $stable(sw_en));

    p_keep_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(sw_en) & sw_reg[N_SW-1:0]) & ~sw_en) == '0));
endmodule

bind bbm_switch_seq bbm_switch_seq_chk #(.N_SW(N_SW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .sw_en   (sw_en),
    .sw_reg  (sw_reg),
    .busy    (busy),
    .in_wait (in_wait)
);

// File: tb/test_bbm_switch_seq.sv
module test_bbm_switch_seq;
    localparam int N  = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [6:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [DW-1:0] dead_cycles = '0;
    logic [N-1:0]  sw_en;
    logic [7:0]    sw_reg;
    logic          busy;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    bit mon_on = 1'b0;

    bbm_switch_seq #(.N_SW(N), .DEAD_W(DW)) i_bbm_switch_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dead_cycles(dead_cycles),
        .sw_en(sw_en), .sw_reg(sw_reg), .busy(busy)
    );

    always #10 clk = ~clk;

    // Reference model built from the requirements.
    logic [N-1:0] m_en, m_tgt, m_reg, m_pend;
    bit m_wait, m_pv;
    int m_cnt;

    function automatic int eff_dead(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    always @(posedge clk) begin
        logic [N-1:0] v;
        bit hit;
        hit = wr_en && wr_addr == 7'h01;
        if (!rst_n) begin
            m_en = '0; m_tgt = '0; m_reg = '0; m_pend = '0;
            m_wait = 0; m_pv = 0; m_cnt = 0;
        end else if (m_wait) begin
            if (hit) begin m_pend = wr_data[N-1:0]; m_pv = 1; end
            if (m_cnt == 0) begin m_en = m_tgt; m_wait = 0; end
            else m_cnt--;
        end else if (hit || m_pv) begin
            v = hit ? wr_data[N-1:0] : m_pend;
            m_pv = 0;
            m_reg = v;
            if ((v & ~m_en) != '0) begin
                m_en = m_en & v; m_tgt = v; m_wait = 1;
                m_cnt = eff_dead(int'(dead_cycles)) - 1;
            end else m_en = v;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    logic [N-1:0] prev_en = '0;
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            check(sw_en == m_en, "R5", sw_en, m_en);
            check(busy == (m_wait || m_pv), "R8", busy, m_wait || m_pv);
            check(sw_reg == {{(8-N){1'b0}}, m_reg}, "R10", sw_reg, m_reg);
            check(!(((sw_en & ~prev_en) != '0) && ((~sw_en & prev_en) != '0)),
                  "R11", sw_en, prev_en);
        end
        prev_en = sw_en;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_0b0b));
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        check(sw_en == '0, "R1", sw_en, 0);
        check(sw_reg == 8'h00, "R1", sw_reg, 0);
        check(busy == 1'b0, "R1", busy, 0);
        mon_on = 1'b1;

        // R4 / R5: pure close from all-open with dead time 3
        dead_cycles = 3;
        do_write(7'h01, 8'h01);
        check(sw_en == 8'h00, "R4", sw_en, 8'h00);
        check(busy == 1'b1, "R8", busy, 1);
        step(2);
        check(sw_en == 8'h00, "R5", sw_en, 8'h00);
        step(1);
        check(sw_en == 8'h01, "R5", sw_en, 8'h01);
        check(busy == 1'b0, "R8", busy, 0);

        // R2 / R4: swap first switch for second (data 0x02)
        do_write(7'h01, 8'h02);
        check(sw_en == 8'h00, "R4", sw_en, 8'h00);
        check(sw_reg == 8'h02, "R10", sw_reg, 8'h02);
        step(3);
        check(sw_en == 8'h02, "R2", sw_en, 8'h02);

        // R6: overlapping update keeps bit 1 on throughout
        do_write(7'h01, 8'h03);
        check(sw_en == 8'h02, "R6", sw_en, 8'h02);
        step(1);
        check(sw_en == 8'h02, "R6", sw_en, 8'h02);
        step(1);
        check(sw_en == 8'h02, "R6", sw_en, 8'h02);
        step(1);
        check(sw_en == 8'h03, "R2", sw_en, 8'h03);

        // R7: open-only update completes at once
        do_write(7'h01, 8'h01);
        check(sw_en == 8'h01, "R7", sw_en, 8'h01);
        check(busy == 1'b0, "R7", busy, 0);

        // R3: other address and idle strobe are ignored
        do_write(7'h02, 8'hFF);
        check(sw_en == 8'h01, "R3", sw_en, 8'h01);
        check(sw_reg == 8'h01, "R3", sw_reg, 8'h01);
        wr_en = 1'b0; wr_addr = 7'h01; wr_data = 8'hFF;
        step(4);
        check(sw_en == 8'h01, "R3", sw_en, 8'h01);
        check(sw_reg == 8'h01, "R3", sw_reg, 8'h01);

        // R9: two writes queued during a wait, the last one wins
        dead_cycles = 5;
        do_write(7'h01, 8'h80);
        check(sw_en == 8'h00, "R4", sw_en, 8'h00);
        do_write(7'h01, 8'h40);
        do_write(7'h01, 8'h20);
        step(3);
        check(sw_en == 8'h80, "R9", sw_en, 8'h80);
        check(busy == 1'b1, "R9", busy, 1);
        step(1);
        check(sw_en == 8'h00, "R9", sw_en, 8'h00);
        check(sw_reg == 8'h20, "R9", sw_reg, 8'h20);
        step(5);
        check(sw_en == 8'h20, "R9", sw_en, 8'h20);
        check(busy == 1'b0, "R9", busy, 0);

        // R5: dead time zero still waits one edge
        dead_cycles = 0;
        do_write(7'h01, 8'h21);
        check(sw_en == 8'h20, "R5", sw_en, 8'h20);
        step(1);
        check(sw_en == 8'h21, "R5", sw_en, 8'h21);

        // Constrained random writes checked by the per-cycle model
        for (int i = 0; i < 4000; i++) begin
            wr_en = ($urandom % 3) == 0;
            wr_addr = (($urandom % 5) == 0) ? 7'($urandom) : 7'h01;
            wr_data = 8'($urandom);
            dead_cycles = DW'($urandom % 5);
            step(1);
        end
        wr_en = 1'b0;
        step(10);
        summary();
    end
endmodule